// File: doc/BRIEF.md
# Bridge Transaction Forwarding Decoder

This block sits beside a two-port bus bridge and decides, for each transaction that appears on either side, whether the bridge should carry it across. If it should, the block also says in which direction. A transaction is described by its address, its kind (I/O, memory or prefetchable memory) and the side that started it. The decoder answers one cycle later with exactly one of three results: claim downstream (primary to secondary), claim upstream (secondary to primary), or ignore. The address is passed along unchanged, because the bridge does no translation.

Decoding is inverted between the two sides. Each kind of transaction has two programmable windows, each given by a base and a limit. A primary-side transaction is claimed downstream when it falls inside a window of its own kind. A secondary-side transaction is claimed upstream when it falls outside every window of its own kind. Three command enables gate the result. The I/O enable gates primary I/O. The memory enable gates primary memory and prefetchable memory. The bus-master enable gates everything from the secondary side.

Software loads the windows and enables through a simple write port into a live register set. The decoder only uses a shadow copy, and that copy is refreshed from the live set in each cycle in which the idle input is high. This means a configuration change never takes effect in the middle of a bus transaction.

Top module: `fwd_decoder`

## Requirements
- R1: A primary-side transaction (txn_src=0) whose address is inside a window of its own kind is claimed downstream, provided the gating enable for that kind is set. The kind codes are 0 for I/O, 1 for memory, 2 for prefetchable memory and 3 for reserved.
- R2: A secondary-side transaction (txn_src=1) whose address is outside every window of its own kind is claimed upstream when the master enable is set.
- R3: A primary-side transaction that misses every window of its kind is ignored. A secondary-side transaction that hits a window of its kind is ignored. Windows of other kinds play no part in the decision.
- R4: When the I/O enable (command bit 0) is clear, primary-side I/O transactions are ignored. Primary memory transactions are not affected.
- R5: When the memory enable (command bit 1) is clear, primary-side memory and prefetchable transactions are ignored. Primary I/O transactions are not affected.
- R6: When the master enable (command bit 2) is clear, every secondary-side transaction is ignored. Primary-side decoding is not affected.
- R7: An address hits a window when base <= address <= limit, compared unsigned, with both ends included. A window whose base is greater than its limit never hits. After reset, every window is in this disabled state.
- R8: The forwarded address output equals the address presented with the transaction.
- R9: The write port loads a live register set. The register index is 2w for the base of window w and 2w+1 for its limit, where windows 0..5 are I/O 0, I/O 1, memory 0, memory 1, prefetchable 0 and prefetchable 1. Index 12 holds the command bits. The decoder uses only a shadow copy, which is loaded from the live set on each clock edge at which cfg_idle is high. While cfg_idle stays low, writes do not change decoding.
- R10: Exactly one of fwd_down, fwd_up and fwd_ignore is high in the cycle after a valid transaction. All three are low in every other cycle, including after reset.
- R11: A transaction with the reserved kind code 3 is ignored from either side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_idle | input | 1 | Both buses idle; refreshes the shadow configuration |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_src | input | 1 | Originating side: 0 primary, 1 secondary |
| txn_kind | input | 2 | Transaction kind code |
| txn_addr | input | 32 | Transaction address |
| fwd_down | output | 1 | Claim, forward downstream |
| fwd_up | output | 1 | Claim, forward upstream |
| fwd_ignore | output | 1 | Transaction not claimed |
| fwd_addr | output | 32 | Forwarded address, unchanged |

## Verification
The decision and the forwarded address are registered once, so they appear at the clock edge that samples txn_valid. The bench drives each transaction on a falling edge, drops the strobe at the next falling edge, and checks the outputs at that point. One more falling edge later, it checks that all three results are low again. A configuration write reaches the live set on the edge after it is driven, and reaches the shadow on the next edge at which cfg_idle is high. The bench therefore holds cfg_idle high for two edges before it relies on new settings. It also sends a transaction while cfg_idle is low to show that the old settings still decide the result.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        KIND_IO   = 2'd0,
        KIND_MEM  = 2'd1,
        KIND_PREF = 2'd2,
        KIND_RSVD = 2'd3
    } kind_e;

    localparam int NUM_KINDS = 3;

    typedef struct packed {
        logic io_en;
        logic mem_en;
        logic master_en;
    } cmd_t;
endpackage

// File: rtl/fwd_cfg_bank.sv
module fwd_cfg_bank
    import fwd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 6,
    parameter int IDX_W   = 4,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  logic [DATA_W-1:0]               cfg_wdata,
    input  logic                            cfg_idle,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  limit_o,
    output cmd_t                            cmd_o
);
    localparam int CMD_IDX = 2 * NUM_WIN;

    typedef struct packed {
        logic [NUM_WIN-1:0][ADDR_W-1:0] base;
        logic [NUM_WIN-1:0][ADDR_W-1:0] limit;
        cmd_t                           cmd;
    } bank_t;

    typedef struct packed {
        bank_t live;
        bank_t shadow;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (cfg_idx == IDX_W'(2 * w))
                    st_d.live.base[w] = cfg_wdata[ADDR_W-1:0];
                if (cfg_idx == IDX_W'(2 * w + 1))
                    st_d.live.limit[w] = cfg_wdata[ADDR_W-1:0];
            end
            if (cfg_idx == IDX_W'(CMD_IDX)) begin
                st_d.live.cmd.io_en     = cfg_wdata[0];
                st_d.live.cmd.mem_en    = cfg_wdata[1];
                st_d.live.cmd.master_en = cfg_wdata[2];
            end
        end
        if (cfg_idle)
            st_d.shadow = st_q.live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                st_q.live.base[w]    <= '1;
                st_q.live.limit[w]   <= '0;
                st_q.shadow.base[w]  <= '1;
                st_q.shadow.limit[w] <= '0;
            end
            st_q.live.cmd   <= '0;
            st_q.shadow.cmd <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o  = st_q.shadow.base;
    assign limit_o = st_q.shadow.limit;
    assign cmd_o   = st_q.shadow.cmd;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_idle) |-> ($stable(base_o) && $stable(limit_o) && $stable(cmd_o))); // R9
endmodule

// File: rtl/fwd_win_match.sv
module fwd_win_match #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 6
) (
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  base_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  limit_i,
    output logic [NUM_WIN-1:0]              hit_o
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic above_base, below_limit;
        assign above_base  = (addr_i >= base_i[w]);
        assign below_limit = (addr_i <= limit_i[w]);
        assign hit_o[w]    = above_base && below_limit;
    end
endmodule

// File: rtl/fwd_decoder.sv
module fwd_decoder
    import fwd_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int WIN_PER_KIND = 2,
    parameter int IDX_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_idle,
    input  logic              txn_valid,
    input  logic              txn_src,
    input  logic [1:0]        txn_kind,
    input  logic [ADDR_W-1:0] txn_addr,
    output logic              fwd_down,
    output logic              fwd_up,
    output logic              fwd_ignore,
    output logic [ADDR_W-1:0] fwd_addr
);
    localparam int NUM_WIN = NUM_KINDS * WIN_PER_KIND;

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_s, limit_s;
    cmd_t                           cmd_s;
    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_KINDS-1:0]           kind_hit;

    fwd_cfg_bank #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN),
        .IDX_W  (IDX_W),
        .DATA_W (32)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_wdata(cfg_wdata),
        .cfg_idle (cfg_idle),
        .base_o   (base_s),
        .limit_o  (limit_s),
        .cmd_o    (cmd_s)
    );

    fwd_win_match #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN)
    ) match_i (
        .addr_i (txn_addr),
        .base_i (base_s),
        .limit_i(limit_s),
        .hit_o  (win_hit)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        assign kind_hit[k] = |win_hit[k*WIN_PER_KIND +: WIN_PER_KIND];
    end

    typedef struct packed {
        logic              down;
        logic              up;
        logic              ign;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t out_d, out_q;
    logic sel_hit, sel_ok, prim_en;

    always_comb begin
        sel_hit = 1'b0;
        sel_ok  = 1'b1;
        prim_en = cmd_s.mem_en;
        case (kind_e'(txn_kind))
            KIND_IO:   begin sel_hit = kind_hit[0]; prim_en = cmd_s.io_en; end
            KIND_MEM:  sel_hit = kind_hit[1];
            KIND_PREF: sel_hit = kind_hit[2];
            default:   sel_ok = 1'b0;
        endcase

        out_d      = '0;
        out_d.addr = out_q.addr;
        if (txn_valid) begin
            out_d.addr = txn_addr;
            if (!txn_src) begin
                if (sel_ok && prim_en && sel_hit) out_d.down = 1'b1;
                else                              out_d.ign  = 1'b1;
            end else begin
                if (sel_ok && cmd_s.master_en && !sel_hit) out_d.up  = 1'b1;
                else                                       out_d.ign = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fwd_down   = out_q.down;
    assign fwd_up     = out_q.up;
    assign fwd_ignore = out_q.ign;
    assign fwd_addr   = out_q.addr;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid) |-> ($countones({fwd_down, fwd_up, fwd_ignore}) == 1)); // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(txn_valid) |-> ({fwd_down, fwd_up, fwd_ignore} == 3'b000)); // R10
    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid) |-> (fwd_addr == $past(txn_addr))); // R8
    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid && txn_src && !cmd_s.master_en) |-> fwd_ignore); // R6
    AST_IO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid && !txn_src && txn_kind == 2'd0 && !cmd_s.io_en) |-> fwd_ignore); // R4
    AST_SIDE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid) |-> (!(fwd_down && $past(txn_src)) && !(fwd_up && !$past(txn_src)))); // R1
endmodule

// File: tb/fwd_decoder_tb_top.sv
module fwd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_idle = 1'b0;
    logic        txn_valid = 1'b0;
    logic        txn_src = 1'b0;
    logic [1:0]  txn_kind = '0;
    logic [31:0] txn_addr = '0;
    logic        fwd_down, fwd_up, fwd_ignore;
    logic [31:0] fwd_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    localparam logic [2:0] RES_DN = 3'b100, RES_UP = 3'b010, RES_IG = 3'b001;

    always #2.5 clk = ~clk;

    fwd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_idle(cfg_idle), .txn_valid(txn_valid),
        .txn_src(txn_src), .txn_kind(txn_kind), .txn_addr(txn_addr),
        .fwd_down(fwd_down), .fwd_up(fwd_up), .fwd_ignore(fwd_ignore),
        .fwd_addr(fwd_addr)
    );

    task automatic check_res(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {fwd_down, fwd_up, fwd_ignore};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: result %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] idx, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic apply_cfg();
        @(negedge clk);
        cfg_idle = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cfg_idle = 1'b0;
    endtask

    task automatic txn(string req, logic src, logic [1:0] kind, logic [31:0] addr, logic [2:0] exp);
        @(negedge clk);
        txn_valid = 1'b1; txn_src = src; txn_kind = kind; txn_addr = addr;
        @(negedge clk);
        txn_valid = 1'b0;
        check_res(req, exp);
        n_checks++;
        if (fwd_addr !== addr) begin
            n_fails++;
            $display("FAIL R8: addr %h expected %h", fwd_addr, addr);
        end
        @(negedge clk);
        check_res("R10 quiet", 3'b000);
    endtask

    task automatic t_reset();
        check_res("R10 reset", 3'b000);
        txn("R7 reset windows disabled", 1'b0, 2'd0, 32'h0, RES_IG);
    endtask

    task automatic t_program();
        wr(4'd0, 32'h0000_1000);  wr(4'd1, 32'h0000_1FFF);
        wr(4'd2, 32'h0000_8000);  wr(4'd3, 32'h0000_80FF);
        wr(4'd4, 32'h4000_0000);  wr(4'd5, 32'h4FFF_FFFF);
        wr(4'd6, 32'h9000_0000);  wr(4'd7, 32'h8000_0000);
        wr(4'd8, 32'hC000_0000);  wr(4'd9, 32'hC0FF_FFFF);
        wr(4'd10, 32'hD000_0000); wr(4'd11, 32'hD000_0FFF);
        wr(4'd12, 32'h7);
        apply_cfg();
    endtask

    task automatic t_downstream();
        txn("R1 io window0", 1'b0, 2'd0, 32'h0000_1800, RES_DN);
        txn("R1 io window1", 1'b0, 2'd0, 32'h0000_8000, RES_DN);
        txn("R1 mem window", 1'b0, 2'd1, 32'h4000_1234, RES_DN);
        txn("R1 pref window", 1'b0, 2'd2, 32'hD000_0800, RES_DN);
    endtask

    task automatic t_bounds();
        txn("R7 base inclusive", 1'b0, 2'd0, 32'h0000_1000, RES_DN);
        txn("R7 limit inclusive", 1'b0, 2'd0, 32'h0000_1FFF, RES_DN);
        txn("R7 below base", 1'b0, 2'd0, 32'h0000_0FFF, RES_IG);
        txn("R7 above limit", 1'b0, 2'd0, 32'h0000_2000, RES_IG);
        txn("R7 inverted window primary", 1'b0, 2'd1, 32'h8800_0000, RES_IG);
        txn("R7 inverted window secondary", 1'b1, 2'd1, 32'h8800_0000, RES_UP);
    endtask

    task automatic t_inverse();
        txn("R3 primary miss", 1'b0, 2'd0, 32'h0000_3000, RES_IG);
        txn("R3 secondary hit", 1'b1, 2'd0, 32'h0000_1800, RES_IG);
        txn("R3 primary other kind", 1'b0, 2'd1, 32'h0000_1800, RES_IG);
        txn("R3 secondary other kind", 1'b1, 2'd1, 32'h0000_1800, RES_UP);
        txn("R2 secondary io miss", 1'b1, 2'd0, 32'h0000_3000, RES_UP);
        txn("R2 secondary pref miss", 1'b1, 2'd2, 32'h0000_0010, RES_UP);
        txn("R2 secondary pref hit", 1'b1, 2'd2, 32'hC000_0000, RES_IG);
        txn("R11 reserved primary", 1'b0, 2'd3, 32'h0000_1800, RES_IG);
        txn("R11 reserved secondary", 1'b1, 2'd3, 32'h0000_3000, RES_IG);
    endtask

    task automatic t_shadow();
        wr(4'd12, 32'h0);
        wr(4'd0, 32'h0000_3000);
        txn("R9 old cmd still used", 1'b0, 2'd0, 32'h0000_1800, RES_DN);
        txn("R9 old base still used", 1'b1, 2'd0, 32'h0000_3000, RES_UP);
        apply_cfg();
        txn("R9 new cmd applied", 1'b0, 2'd0, 32'h0000_1800, RES_IG);
        wr(4'd0, 32'h0000_1000);
        wr(4'd12, 32'h7);
        apply_cfg();
        txn("R9 restored", 1'b0, 2'd0, 32'h0000_1800, RES_DN);
    endtask

    task automatic t_enables();
        wr(4'd12, 32'h6); apply_cfg();
        txn("R4 io gated", 1'b0, 2'd0, 32'h0000_1800, RES_IG);
        txn("R4 mem unaffected", 1'b0, 2'd1, 32'h4000_0000, RES_DN);
        wr(4'd12, 32'h5); apply_cfg();
        txn("R5 mem gated", 1'b0, 2'd1, 32'h4000_0000, RES_IG);
        txn("R5 pref gated", 1'b0, 2'd2, 32'hC000_0100, RES_IG);
        txn("R5 io unaffected", 1'b0, 2'd0, 32'h0000_1800, RES_DN);
        wr(4'd12, 32'h3); apply_cfg();
        txn("R6 secondary io gated", 1'b1, 2'd0, 32'h0000_3000, RES_IG);
        txn("R6 secondary mem gated", 1'b1, 2'd1, 32'h0000_0000, RES_IG);
        txn("R6 primary unaffected", 1'b0, 2'd0, 32'h0000_1800, RES_DN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_downstream();
        t_bounds();
        t_inverse();
        t_shadow();
        t_enables();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule